// File: doc/BRIEF.md
# PID-Keyed Section Filter

This block screens sections, already pulled out of a transport stream, against programmable byte patterns. A table of 32 slots holds packet identifiers. Each slot selects a contiguous run of entries from one shared pool of pattern/mask entries. A section arrives one byte per valid cycle, with a start flag on its first byte and the packet identifier of the packet it came from. When any entry owned by the matching slot agrees with the first bytes of the section on every masked bit, the block pulses an accept flag and gives the slot number. A downstream DMA uses that number to choose the memory substream for the section.

The pool holds 320 pattern bytes and 320 mask bytes. A static mode input sets the entry length to 8 bytes, which gives 40 entries, or to 4 bytes, which gives 80 entries. All entries are compared in parallel as the bytes arrive, so the filter keeps up with one byte per clock. That is far above a 13.5 Mbyte/s stream at any practical clock rate.

Top module: `section_filter`

## Requirements
- R1: After reset every slot is disabled and every pattern and mask byte is zero, so no section is accepted until a slot is written; accept_o is low during and after reset.
- R2: A write with cfg_sel_i=0 loads slot cfg_addr_i[4:0] from cfg_wdata_i. The fields are: packet identifier in bits [12:0], first pool entry in bits [19:13], entry count in bits [26:20], and enable in bit 31.
- R3: A write with cfg_sel_i=1 stores a pattern byte and cfg_sel_i=2 stores a mask byte, at pool byte address cfg_addr_i (0..319). The entry length L is 4 when mode4_i=1 and 8 when mode4_i=0. Byte k of entry e sits at address e*L+k.
- R4: A section byte meets byte k of an entry when it equals the pattern byte on every bit where the mask byte has a 1; bits with a 0 in the mask are not compared.
- R5: A section is accepted when at least one entry e with start <= e < start+count meets all of the first L section bytes. Entries outside that range have no effect.
- R6: accept_o is high for exactly one cycle. That cycle is the one after the clock edge that samples the L-th byte of the section. sub_idx_o carries the slot number in that same cycle.
- R7: A section whose packet identifier matches no enabled slot is never accepted.
- R8: A section that ends before L bytes, because a new start flag arrives first, is never accepted. The new start begins a fresh comparison.
- R9: Cycles with sec_valid_i low are ignored. Idle gaps inside a section do not change the result.
- R10: When several enabled slots hold the same packet identifier, the lowest-numbered slot alone decides the section.
- R11: A slot with count 0 never accepts. Entries at or above the mode's capacity (40 in 8-byte mode) never match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode4_i | input | 1 | 1: 4-byte entries, 0: 8-byte entries |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Write target: 0 slot, 1 pattern byte, 2 mask byte |
| cfg_addr_i | input | 9 | Slot number or pool byte address |
| cfg_wdata_i | input | 32 | Write data (slot word or byte in bits [7:0]) |
| sec_valid_i | input | 1 | Section byte valid |
| sec_sof_i | input | 1 | First byte of a section |
| sec_pid_i | input | 13 | Packet identifier of the section |
| sec_data_i | input | 8 | Section byte |
| accept_o | output | 1 | Section accepted (one-cycle pulse) |
| sub_idx_o | output | 5 | Slot and substream index of the accepted section |

## Verification
Several properties are checked on every cycle. The byte position never reaches the entry length while a section is open. Idle cycles leave the comparison state untouched. Every accept pulse follows a valid byte, and it comes from a slot whose count is nonzero. A lookup hit always names an enabled slot that holds the requested identifier. Only the bench scenarios can show the rest: the pool address layout in both modes, mask semantics, range ownership, the priority between duplicate slots, and the rejection of short or unknown sections. The bench does this by sweeping every pool entry in both modes against arithmetically generated patterns.

// File: rtl/sf_pkg.sv
package sf_pkg;
  localparam int NUM_SLOTS  = 32;
  localparam int POOL_BYTES = 320;
  localparam int PID_W      = 13;
  localparam int ENT_W      = 7;
  localparam int LONG_LEN   = 8;
  localparam int SHORT_LEN  = 4;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int CFG_AW     = $clog2(POOL_BYTES);
  localparam int BIDX_W     = $clog2(LONG_LEN);

  typedef enum logic [1:0] {
    SEL_PID  = 2'd0,
    SEL_PAT  = 2'd1,
    SEL_MSK  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic             en;
    logic [ENT_W-1:0] cnt;
    logic [ENT_W-1:0] start;
    logic [PID_W-1:0] pid;
  } slot_t;
endpackage

// File: rtl/sf_pid_table.sv
module sf_pid_table
  import sf_pkg::*;
#(
  parameter  int NS = NUM_SLOTS,
  localparam int SW = $clog2(NS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SW-1:0]    wr_slot_i,
  input  logic [31:0]      wr_data_i,
  input  logic [PID_W-1:0] lk_pid_i,
  output logic             lk_hit_o,
  output logic [SW-1:0]    lk_slot_o,
  input  logic [SW-1:0]    rd_slot_i,
  output logic [ENT_W-1:0] rd_start_o,
  output logic [ENT_W-1:0] rd_cnt_o
);
  slot_t tbl_q [NS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NS; i++) tbl_q[i] <= '0;
    end else if (wr_en_i) begin
      tbl_q[wr_slot_i].pid   <= wr_data_i[12:0];
      tbl_q[wr_slot_i].start <= wr_data_i[19:13];
      tbl_q[wr_slot_i].cnt   <= wr_data_i[26:20];
      tbl_q[wr_slot_i].en    <= wr_data_i[31];
    end
  end

  // descending scan: lowest matching slot wins
  always_comb begin
    lk_hit_o  = 1'b0;
    lk_slot_o = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (tbl_q[i].en && tbl_q[i].pid == lk_pid_i) begin
        lk_hit_o  = 1'b1;
        lk_slot_o = SW'(i);
      end
    end
  end

  assign rd_start_o = tbl_q[rd_slot_i].start;
  assign rd_cnt_o   = tbl_q[rd_slot_i].cnt;

  a_r10_hit_is_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (tbl_q[lk_slot_o].en && tbl_q[lk_slot_o].pid == lk_pid_i));
endmodule

// File: rtl/sf_cond_pool.sv
module sf_cond_pool
  import sf_pkg::*;
#(
  parameter  int POOL_B = POOL_BYTES,
  localparam int NE     = POOL_B / SHORT_LEN,
  localparam int AW     = $clog2(POOL_B)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pat_we_i,
  input  logic              msk_we_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              mode4_i,
  input  logic [BIDX_W-1:0] bidx_i,
  input  logic [7:0]        data_i,
  output logic [NE-1:0]     hit_o
);
  logic [7:0] pat_q [POOL_B];
  logic [7:0] msk_q [POOL_B];
  logic       wr_ok;

  assign wr_ok = int'(wr_addr_i) < POOL_B;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < POOL_B; i++) begin
        pat_q[i] <= '0;
        msk_q[i] <= '0;
      end
    end else begin
      if (pat_we_i && wr_ok) pat_q[wr_addr_i] <= wr_data_i;
      if (msk_we_i && wr_ok) msk_q[wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar e = 0; e < NE; e++) begin : g_ent
    logic [AW-1:0] addr;
    logic          in_cap;
    always_comb begin
      in_cap = mode4_i ? 1'b1 : (e < POOL_B / LONG_LEN);
      if (mode4_i)     addr = AW'(e * SHORT_LEN) + AW'(bidx_i);
      else if (in_cap) addr = AW'(e * LONG_LEN) + AW'(bidx_i);
      else             addr = '0;
    end
    assign hit_o[e] = in_cap && (((data_i ^ pat_q[addr]) & msk_q[addr]) == 8'h00);
  end
endmodule

// File: rtl/sf_match_ctrl.sv
module sf_match_ctrl
  import sf_pkg::*;
#(
  parameter  int NE = POOL_BYTES / SHORT_LEN,
  parameter  int NS = NUM_SLOTS,
  localparam int SW = $clog2(NS),
  localparam int CW = BIDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode4_i,
  input  logic              valid_i,
  input  logic              sof_i,
  input  logic              lk_hit_i,
  input  logic [SW-1:0]     lk_slot_i,
  input  logic [NE-1:0]     hit_i,
  input  logic [ENT_W-1:0]  rd_start_i,
  input  logic [ENT_W-1:0]  rd_cnt_i,
  output logic [SW-1:0]     rd_slot_o,
  output logic [BIDX_W-1:0] bidx_o,
  output logic              accept_o,
  output logic [SW-1:0]     idx_o
);
  logic          act_q;
  logic [CW-1:0] cnt_q;
  logic [NE-1:0] flags_q;
  logic [SW-1:0] slot_q;
  logic          acc_q;
  logic [SW-1:0] idx_q;

  logic [CW-1:0] len, cnt_nxt;
  logic [NE-1:0] flags_nxt, in_rng;
  logic          take, last;

  assign len       = mode4_i ? CW'(SHORT_LEN) : CW'(LONG_LEN);
  assign take      = valid_i && (sof_i ? lk_hit_i : act_q);
  assign cnt_nxt   = sof_i ? CW'(1) : cnt_q + CW'(1);
  assign flags_nxt = sof_i ? hit_i : (flags_q & hit_i);
  assign last      = take && (cnt_nxt == len);
  assign bidx_o    = sof_i ? '0 : cnt_q[BIDX_W-1:0];
  assign rd_slot_o = slot_q;

  for (genvar e = 0; e < NE; e++) begin : g_rng
    localparam logic [ENT_W:0] EV = (ENT_W + 1)'(e);
    assign in_rng[e] = ({1'b0, rd_start_i} <= EV) &&
                       (EV < ({1'b0, rd_start_i} + {1'b0, rd_cnt_i}));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      cnt_q   <= '0;
      flags_q <= '0;
      slot_q  <= '0;
      acc_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      acc_q <= last && |(flags_nxt & in_rng);
      if (last) idx_q <= slot_q;
      if (take) begin
        flags_q <= flags_nxt;
        cnt_q   <= cnt_nxt;
        act_q   <= !last;
        if (sof_i) slot_q <= lk_slot_i;
      end else if (valid_i && sof_i) begin
        act_q <= 1'b0;
      end
    end
  end

  assign accept_o = acc_q;
  assign idx_o    = idx_q;

  a_r8_pos_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q < len));
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(cnt_q) && $stable(flags_q) && $stable(act_q)));
  a_r6_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |-> $past(valid_i));
  a_r11_nonzero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_q |-> ($past(rd_cnt_i) != '0));
endmodule

// File: rtl/section_filter.sv
module section_filter
  import sf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode4_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_sel_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  input  logic              sec_valid_i,
  input  logic              sec_sof_i,
  input  logic [PID_W-1:0]  sec_pid_i,
  input  logic [7:0]        sec_data_i,
  output logic              accept_o,
  output logic [SLOT_W-1:0] sub_idx_o
);
  localparam int NE = POOL_BYTES / SHORT_LEN;

  logic              lk_hit;
  logic [SLOT_W-1:0] lk_slot, rd_slot;
  logic [ENT_W-1:0]  rd_start, rd_cnt;
  logic [BIDX_W-1:0] bidx;
  logic [NE-1:0]     hit_vec;
  logic              pid_we, pat_we, msk_we;

  assign pid_we = cfg_we_i && (cfg_sel_i == SEL_PID);
  assign pat_we = cfg_we_i && (cfg_sel_i == SEL_PAT);
  assign msk_we = cfg_we_i && (cfg_sel_i == SEL_MSK);

  sf_pid_table #(.NS(NUM_SLOTS)) u_tbl (
    .clk_i, .rst_ni,
    .wr_en_i   (pid_we),
    .wr_slot_i (cfg_addr_i[SLOT_W-1:0]),
    .wr_data_i (cfg_wdata_i),
    .lk_pid_i  (sec_pid_i),
    .lk_hit_o  (lk_hit),
    .lk_slot_o (lk_slot),
    .rd_slot_i (rd_slot),
    .rd_start_o(rd_start),
    .rd_cnt_o  (rd_cnt)
  );

  sf_cond_pool #(.POOL_B(POOL_BYTES)) u_pool (
    .clk_i, .rst_ni,
    .pat_we_i (pat_we),
    .msk_we_i (msk_we),
    .wr_addr_i(cfg_addr_i),
    .wr_data_i(cfg_wdata_i[7:0]),
    .mode4_i,
    .bidx_i   (bidx),
    .data_i   (sec_data_i),
    .hit_o    (hit_vec)
  );

  sf_match_ctrl #(.NE(NE), .NS(NUM_SLOTS)) u_ctrl (
    .clk_i, .rst_ni,
    .mode4_i,
    .valid_i   (sec_valid_i),
    .sof_i     (sec_sof_i),
    .lk_hit_i  (lk_hit),
    .lk_slot_i (lk_slot),
    .hit_i     (hit_vec),
    .rd_start_i(rd_start),
    .rd_cnt_i  (rd_cnt),
    .rd_slot_o (rd_slot),
    .bidx_o    (bidx),
    .accept_o  (accept_o),
    .idx_o     (sub_idx_o)
  );

  a_r1_quiet_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(accept_o) |-> $past(sec_valid_i));
endmodule

// File: tb/section_filter_test.sv
module section_filter_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode4 = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [8:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        sec_valid = 1'b0;
  logic        sec_sof = 1'b0;
  logic [12:0] sec_pid = '0;
  logic [7:0]  sec_data = '0;
  logic        accept;
  logic [4:0]  sub_idx;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [7:0] tx [8];
  bit       res_acc, res_bad;
  int       res_idx;

  always #5 clk = ~clk;

  section_filter uut (
    .clk_i(clk), .rst_ni, .mode4_i(mode4),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .sec_valid_i(sec_valid), .sec_sof_i(sec_sof), .sec_pid_i(sec_pid), .sec_data_i(sec_data),
    .accept_o(accept), .sub_idx_o(sub_idx)
  );

  function automatic logic [7:0] patf(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic wr(input int sel, input int addr, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_addr = 9'(addr); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_slot(input int s, input int pid, input int st, input int cnt, input bit en);
    wr(0, s, {en, 4'b0, 7'(cnt), 7'(st), 13'(pid)});
  endtask

  task automatic load_entry(input int base, input int len);
    for (int k = 0; k < len; k++) tx[k] = patf(base + k);
  endtask

  task automatic send(input int pid, input int n, input int gap);
    res_bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (accept) res_bad = 1'b1;
          sec_valid = 1'b0;
        end
      end
      @(negedge clk);
      if (accept) res_bad = 1'b1;
      sec_valid = 1'b1; sec_sof = (i == 0); sec_pid = 13'(pid); sec_data = tx[i];
    end
    @(negedge clk);
    sec_valid = 1'b0; sec_sof = 1'b0;
    res_acc = accept;
    res_idx = int'(sub_idx);
    @(negedge clk);
    if (accept) res_bad = 1'b1;
  endtask

  task automatic expect_sec(input string req, input bit exp_acc, input int exp_idx);
    checks++;
    if (res_acc !== exp_acc || res_bad || (exp_acc && res_idx != exp_idx)) begin
      errors++;
      $display("FAIL %s: accept=%0b idx=%0d stray=%0b, expected accept=%0b idx=%0d",
               req, res_acc, res_idx, res_bad, exp_acc, exp_idx);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (accept !== 1'b0) begin
      errors++;
      $display("FAIL R1: accept=%0b during reset, expected 0", accept);
    end
    rst_ni = 1'b1;
    // R1: zero masks would match anything, but every slot is disabled
    for (int k = 0; k < 8; k++) tx[k] = 8'(k);
    send(0, 8, 0);
    expect_sec("R1", 1'b0, 0);

    // R3: pool layout, all masks set
    for (int a = 0; a < 320; a++) begin
      wr(1, a, 32'(patf(a)));
      wr(2, a, 32'hFF);
    end
    // R3/R2: 4-byte mode sweep over all 80 entries through slot 0
    mode4 = 1'b1;
    for (int e = 0; e < 80; e++) begin
      wr_slot(0, 13'h055, e, 1, 1'b1);
      load_entry(e * 4, 4);
      send(13'h055, 4, 0);
      expect_sec("R3 mode4", 1'b1, 0);
    end
    // R3/R2: 8-byte mode sweep over 40 entries through slot 9
    mode4 = 1'b0;
    wr_slot(0, 0, 0, 0, 1'b0);
    for (int e = 0; e < 40; e++) begin
      wr_slot(9, 13'h0AB, e, 1, 1'b1);
      load_entry(e * 8, 8);
      send(13'h0AB, 8, 0);
      expect_sec("R3 mode8", 1'b1, 9);
    end
    // R11: entry 40 lies beyond 8-byte capacity
    wr_slot(9, 13'h0AB, 40, 1, 1'b1);
    load_entry(320, 8);
    send(13'h0AB, 8, 0);
    expect_sec("R11 capacity", 1'b0, 0);
    wr_slot(9, 0, 0, 0, 1'b0);

    // R5: slot 3 owns entries 2 and 3
    wr_slot(3, 13'h100, 2, 2, 1'b1);
    load_entry(24, 8);
    send(13'h100, 8, 0);
    expect_sec("R5 in range", 1'b1, 3);
    load_entry(40, 8);
    send(13'h100, 8, 0);
    expect_sec("R5 out of range", 1'b0, 0);
    load_entry(8, 8);
    send(13'h100, 8, 0);
    expect_sec("R5 below range", 1'b0, 0);
    // R9: idle gaps inside the section
    load_entry(16, 8);
    send(13'h100, 8, 3);
    expect_sec("R9 gaps", 1'b1, 3);
    // R4: mask high nibble off on entry 2 byte 0
    wr(2, 16, 32'h0F);
    load_entry(16, 8);
    tx[0] = tx[0] ^ 8'hF0;
    send(13'h100, 8, 0);
    expect_sec("R4 masked bits", 1'b1, 3);
    load_entry(16, 8);
    tx[0] = tx[0] ^ 8'h01;
    send(13'h100, 8, 0);
    expect_sec("R4 compared bit", 1'b0, 0);
    wr(2, 16, 32'hFF);
    // R8: short section then a full one
    load_entry(16, 8);
    send(13'h100, 5, 0);
    expect_sec("R8 short", 1'b0, 0);
    send(13'h100, 8, 0);
    expect_sec("R8 restart", 1'b1, 3);
    // R7: unknown and disabled identifiers
    send(13'h101, 8, 0);
    expect_sec("R7 unknown", 1'b0, 0);
    wr_slot(3, 13'h100, 2, 2, 1'b0);
    send(13'h100, 8, 0);
    expect_sec("R7 disabled", 1'b0, 0);
    // R10/R11: duplicate identifier, lowest slot has count 0
    wr_slot(1, 13'h200, 0, 0, 1'b1);
    wr_slot(7, 13'h200, 2, 1, 1'b1);
    send(13'h200, 8, 0);
    expect_sec("R10 R11 zero count shadows", 1'b0, 0);
    wr_slot(1, 13'h200, 3, 1, 1'b1);
    load_entry(24, 8);
    send(13'h200, 8, 0);
    expect_sec("R10 lowest slot", 1'b1, 1);
    load_entry(16, 8);
    send(13'h200, 8, 0);
    expect_sec("R10 higher slot ignored", 1'b0, 0);
    // R6: back-to-back sections, one pulse each
    wr_slot(1, 13'h200, 2, 1, 1'b1);
    send(13'h200, 8, 0);
    expect_sec("R6 pulse 1", 1'b1, 1);
    send(13'h200, 8, 0);
    expect_sec("R6 pulse 2", 1'b1, 1);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule